// File: doc/BRIEF.md
# Dual-Mode Baud Tick Generator

This block turns the system clock into a stream of single-cycle oversampling ticks, sixteen per bit time, for the serial transmitter and receiver next to it. It has two ways of making that rate. The integer divider suits low bit rates where the clock is a clean multiple of sixteen times the baud. The fractional phase accumulator suits high bit rates where the clock is not such a multiple.

A single rate word is shared by both modes. In divider mode it holds clock / (16 x baud), and a tick follows every that many clocks. In accumulator mode it holds baud x 16 x 2^W / clock, where W is the rate width. A W-bit phase register adds that word every clock and flags a tick on each carry-out, so the tick rate is clock x rate / 2^W. Accumulator mode is meant for rates above 19200 baud. A run input gates everything. While run is low, both engines are held at zero, so the first tick after a restart always lands in the same place.

The inputs are plain register values (rate word, mode bit, run bit). The output is a bare pulse: no data moves through the block, so it has no handshake.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and before run has been high, tick is 0.
- R2: In divider mode (frac_mode = 0) with rate N >= 1, the registered tick is 1 on the first cycle after the first run-high clock edge. It is then 1 on exactly every N-th cycle after that, and 0 on all other cycles.
- R3: In divider mode a rate of 0 behaves like a rate of 1.
- R4: In divider mode a rate of 1 gives a tick on every cycle while running, which is the highest rate (clock / 16 baud).
- R5: In accumulator mode (frac_mode = 1), the output on the i-th cycle after run rises (i = 0, 1, ...) is a tick exactly when floor((i+1) x R / 2^W) differs from floor(i x R / 2^W). So no tick comes on the first cycle, and a rate of 0 gives no ticks at all.
- R6: In accumulator mode, any 2^W consecutive cycles that start at a run rising edge hold exactly R ticks.
- R7: One cycle after run is sampled low, tick is 0 and stays 0 while run stays low. Both engines are cleared while stopped, so each restart repeats the pattern of R2 or R5 from i = 0.
- R8: The mode bit picks the engine: 1 selects the accumulator, 0 selects the divider. The same rate word then gives the pattern of R5 or R2 respectively.
- R9: In divider mode with rate N >= 2, a tick is never followed directly by another tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Generator enable; low stops the block and clears both engines |
| frac_mode | input | 1 | 1 selects the phase accumulator, 0 the integer divider |
| rate | input | RATE_W | Divider reload value, or accumulator increment |
| tick | output | 1 | Registered single-cycle oversample tick |

## Verification
The bench builds the block with RATE_W = 8. That makes all 256 rate words reachable in both modes, and it shrinks one full wrap of the accumulator to 256 cycles. Every rate is swept in divider mode over two full periods and in accumulator mode over one full wrap. Each run starts from a stopped state, so the zero and unit corner values, the restart behaviour and the exact tick count per wrap are all covered, and each cycle is compared with an arithmetic model.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;
  typedef enum logic {
    MODE_DIVIDE = 1'b0,
    MODE_PHASE  = 1'b1
  } tick_mode_e;
endpackage

// File: rtl/btg_int_divider.sv
// Integer engine: counts down from rate-1 and hits when the count is zero.
module btg_int_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] rate,
  output logic         hit
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] eff_rate;
  logic [W-1:0] reload;

  // R3: a zero rate word is treated as one.
  assign eff_rate = (rate == '0) ? W'(1) : rate;
  assign reload   = eff_rate - W'(1);
  assign hit      = en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - W'(1);
    end
  end
endmodule

// File: rtl/btg_phase_accum.sv
// Fractional engine: adds the increment every clock, hits on carry-out.
module btg_phase_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] incr,
  output logic         hit
);
  logic [W-1:0] phase_q;
  logic [W:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, incr};
  assign hit = en && sum[W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (!en) begin
      phase_q <= '0;
    end else begin
      phase_q <= sum[W-1:0];
    end
  end
endmodule

// File: rtl/btg_tick_select.sv
// Picks the active engine's hit and registers it as the output tick.
module btg_tick_select
  import baud_tick_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  tick_mode_e mode,
  input  logic       div_hit,
  input  logic       acc_hit,
  output logic       tick
);
  logic pick;

  always_comb begin
    unique case (mode)
      MODE_PHASE:  pick = acc_hit;
      default:     pick = div_hit;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= 1'b0;
    end else begin
      tick <= run && pick;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frac_mode,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int ACC_W = RATE_W;

  tick_mode_e mode_sel;
  logic       div_en;
  logic       acc_en;
  logic       div_hit;
  logic       acc_hit;

  assign mode_sel = tick_mode_e'(frac_mode);
  assign div_en   = run && (mode_sel == MODE_DIVIDE);
  assign acc_en   = run && (mode_sel == MODE_PHASE);

  btg_int_divider #(.W(RATE_W)) div_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (div_en),
    .rate  (rate),
    .hit   (div_hit)
  );

  btg_phase_accum #(.W(ACC_W)) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (acc_en),
    .incr  (rate),
    .hit   (acc_hit)
  );

  btg_tick_select sel_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .mode    (mode_sel),
    .div_hit (div_hit),
    .acc_hit (acc_hit),
    .tick    (tick)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              frac_mode,
  input logic [RATE_W-1:0] rate,
  input logic              tick
);
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick); // R7

  AST_DIV_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && !frac_mode) |=> tick); // R2

  AST_ACC_NO_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(run) && frac_mode) |=> !tick); // R5

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !frac_mode && $past(run) && !$past(frac_mode)
     && ($past(rate) > RATE_W'(1))) |=> !tick); // R9
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.RATE_W(RATE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .frac_mode (frac_mode),
  .rate      (rate),
  .tick      (tick)
);

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;
  localparam int W = 8;
  localparam int SPAN = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic         frac_mode = 1'b0;
  logic [W-1:0] rate = '0;
  logic         tick;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen #(.RATE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .frac_mode(frac_mode), .rate(rate), .tick(tick)
  );

  task automatic check(input string req, input logic act, input logic exp, input int r, input int i);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s rate=%0d cyc=%0d tick=%0b expected=%0b", req, r, i, act, exp);
    end
  endtask

  // Stop for two cycles; tick must be quiet (R7)
  task automatic stop_gen(input int r);
    @(negedge clk);
    run = 1'b0;
    repeat (2) begin
      @(posedge clk); @(negedge clk);
      check("R7", tick, 1'b0, r, -1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", tick, 1'b0, 0, 0);
    rst_n = 1'b1;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R1", tick, 1'b0, 0, 0);
    end

    // Divider sweep: R2, R3, R4, R8
    for (int r = 0; r < SPAN; r++) begin
      int eff;
      eff = (r == 0) ? 1 : r;
      stop_gen(r);
      frac_mode = 1'b0;
      rate = W'(r);
      run = 1'b1;
      for (int i = 0; i < 2 * eff + 1; i++) begin
        @(posedge clk); @(negedge clk);
        if (r == 0)      check("R3", tick, 1'b1, r, i);
        else if (r == 1) check("R4", tick, 1'b1, r, i);
        else             check("R2", tick, (i % eff) == 0, r, i);
      end
    end

    // Accumulator sweep: R5, R6, R8
    for (int r = 0; r < SPAN; r++) begin
      int seen;
      seen = 0;
      stop_gen(r);
      frac_mode = 1'b1;
      rate = W'(r);
      run = 1'b1;
      for (int i = 0; i < SPAN; i++) begin
        logic exp;
        exp = (((i + 1) * r) >> W) != ((i * r) >> W);
        @(posedge clk); @(negedge clk);
        check(r == 0 ? "R8" : "R5", tick, exp, r, i);
        if (tick === 1'b1) seen++;
      end
      checks++;
      if (seen != r) begin
        fails++;
        $display("FAIL R6 rate=%0d ticks=%0d expected=%0d", r, seen, r);
      end
    end

    stop_gen(0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule